// File: doc/BRIEF.md
# Channel Access Unit Framer and Serializer

This block turns fixed-length transfer frames waiting in an upstream byte FIFO into a continuous serial bit stream. Each output unit starts with a 32-bit sync marker. The 1100 frame bytes follow, and then 160 bytes of Reed-Solomon parity. The parity is computed inside the block by shift-register dividers that are interleaved five deep. Every unit is 1264 bytes long, and units follow one another with no gap.

The block runs from a single clock at the serial bit rate, for example 80 MHz for an 80 Mb/s line. A three-bit phase counter divides that clock into byte slots of eight cycles, so the byte-side work (FIFO reads, encoder updates and byte selection) happens at one eighth of the clock rate. At the start of every unit the block samples `frame_ready`, which the FIFO side raises when a whole frame is stored.
- If `frame_ready` is high, the block pulls that frame one byte per slot.
- If it is low, the block sends a fill frame made of a constant byte. The line never pauses.

Top module: `cadu_serializer`

## Requirements
- R1: After reset is released, the first unit starts on the first rising clock edge. Units are 1264 bytes (10112 clocks) long and follow back to back with no idle clocks. Unit byte 0 starts on the first edge, and byte k of a unit starts 8k clocks later.
- R2: Unit bytes 0 to 3 carry the sync marker 0x1ACFFC1D, the byte 0x1A first.
- R3: Each byte is sent one bit per clock for eight clocks, most significant bit first.
- R4: `frame_ready` is sampled only on the edge that starts a unit, and that sample decides the whole unit. A change of `frame_ready` at any other time does not alter the unit in progress.
- R5: If the sample was 1, `fifo_rd` pulses exactly 1100 times in the unit, once per byte slot, each pulse one clock wide.
  - The byte presented on `fifo_data` in the clock after a pulse goes out as unit byte 4 to 1103, in read order.
  - Its most significant bit appears on `ser_out` three clocks after the pulse clock.
- R6: If the sample was 0, `fifo_rd` stays low for the whole unit and unit bytes 4 to 1103 all equal the fill byte 0x55.
- R7: Unit bytes 1104 to 1263 are Reed-Solomon (255,223) parity with interleave depth 5. The code is defined as follows:
  - The field is GF(256) with primitive polynomial 0x11D and generator element 0x02. The generator polynomial has roots alpha^0 to alpha^31.
  - Frame byte j (0 to 1099) belongs to interleave j mod 5. The sync marker is not encoded.
  - Parity byte p (0 to 159) is the coefficient of x^(31 - floor(p/5)) in the remainder of interleave p mod 5.
  - Each codeword is shortened by 3 leading virtual zero bytes, which are never sent.
- R8: While reset is asserted, `ser_out` and `fifo_rd` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock; a byte slot is 8 cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_ready | input | 1 | High when a complete frame is waiting in the FIFO |
| fifo_data | input | 8 | FIFO read data, valid from the clock after a read pulse |
| fifo_rd | output | 1 | One-clock read request for the next frame byte |
| ser_out | output | 1 | Serial output stream, MSB first |

## Verification
The hardest situation to reach is a disagreement between the FIFO's state and the unit boundary. This happens when a frame lands in the FIFO in the middle of a fill unit, or when whole frames sit in the FIFO while `frame_ready` is held low across a boundary. The stimulus creates both cases. It pushes a frame partway through a fill unit and withholds `frame_ready` over one boundary while two frames are queued. The behavioural model then expects fill for that unit, followed by the two stored frames in consecutive units. Parity is compared bit by bit against a table-driven long division over incrementing, pseudo-random, all-ones and all-zero frames, as well as fill frames.

// File: rtl/cadu_serializer.sv
module cadu_serializer #(
  parameter int          FRAME_BYTES = 1100,
  parameter int          DEPTH       = 5,
  parameter int          NPAR        = 32,
  parameter logic [31:0] SYNC        = 32'h1ACFFC1D,
  parameter logic [7:0]  FILL        = 8'h55,
  parameter logic [8:0]  PRIM        = 9'h11D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_ready,
  input  logic [7:0] fifo_data,
  output logic       fifo_rd,
  output logic       ser_out
);

  localparam int UNIT     = 4 + FRAME_BYTES + DEPTH * NPAR;
  localparam int IW       = $clog2(UNIT);
  localparam int DW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int DATA_END = 4 + FRAME_BYTES;
  localparam logic [IW-1:0] I_DATA = IW'(4);
  localparam logic [IW-1:0] I_PAR  = IW'(DATA_END);
  localparam logic [IW-1:0] I_LAST = IW'(UNIT - 1);
  localparam logic [DW-1:0] IL_LAST = DW'(DEPTH - 1);

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = x[7] ? ({x[6:0], 1'b0} ^ PRIM[7:0]) : {x[6:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [NPAR*8-1:0] gen_poly();
    logic [(NPAR+1)*8-1:0] c;
    logic [7:0] root;
    c = '0;
    c[7:0] = 8'h01;
    root = 8'h01;
    for (int k = 0; k < NPAR; k++) begin
      for (int i = k + 1; i >= 1; i--)
        c[8*i +: 8] = c[8*(i-1) +: 8] ^ gmul(c[8*i +: 8], root);
      c[7:0] = gmul(c[7:0], root);
      root = gmul(root, 8'h02);
    end
    return c[NPAR*8-1:0];
  endfunction

  localparam logic [NPAR*8-1:0] GEN = gen_poly();

  logic [2:0]    ph;
  logic [IW-1:0] nidx;
  logic [7:0]    sr;
  logic          use_fifo;
  logic [DW-1:0] il;
  logic [7:0]    par [DEPTH][NPAR];

  logic [7:0] par_top, data_byte, sync_byte, next_byte, fb;
  logic       load, in_sync, in_data;

  assign load      = (ph == 3'd7);
  assign in_sync   = (nidx < I_DATA);
  assign in_data   = !in_sync && (nidx < I_PAR);
  assign data_byte = use_fifo ? fifo_data : FILL;
  assign sync_byte = SYNC[8*(3 - int'(nidx[1:0])) +: 8];
  assign fb        = data_byte ^ par_top;
  assign next_byte = in_sync ? sync_byte : (in_data ? data_byte : par_top);
  assign fifo_rd   = (ph == 3'd5) && in_data && use_fifo;
  assign ser_out   = sr[7];

  always_comb begin
    par_top = 8'h00;
    for (int d = 0; d < DEPTH; d++)
      if (il == DW'(d)) par_top = par[d][NPAR-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= 3'd7;
      nidx     <= '0;
      sr       <= 8'h00;
      use_fifo <= 1'b0;
      il       <= '0;
      for (int d = 0; d < DEPTH; d++)
        for (int i = 0; i < NPAR; i++) par[d][i] <= 8'h00;
    end else begin
      ph <= ph + 3'd1;
      if (!load) begin
        sr <= {sr[6:0], 1'b0};
      end else begin
        sr   <= next_byte;
        nidx <= (nidx == I_LAST) ? '0 : nidx + IW'(1);
        if (in_sync) begin
          il <= '0;
          if (nidx == '0) begin
            use_fifo <= frame_ready;
            for (int d = 0; d < DEPTH; d++)
              for (int i = 0; i < NPAR; i++) par[d][i] <= 8'h00;
          end
        end else begin
          il <= (il == IL_LAST) ? '0 : il + DW'(1);
          for (int d = 0; d < DEPTH; d++) begin
            if (il == DW'(d)) begin
              par[d][0] <= in_data ? gmul(fb, GEN[7:0]) : 8'h00;
              for (int i = 1; i < NPAR; i++)
                par[d][i] <= par[d][i-1] ^ (in_data ? gmul(fb, GEN[8*i +: 8]) : 8'h00);
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/cadu_serializer_chk.sv
module cadu_serializer_chk #(
  parameter int          FRAME_BYTES = 1100,
  parameter int          IW          = 11,
  parameter logic [31:0] SYNC        = 32'h1ACFFC1D
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_rd,
  input logic          ser_out,
  input logic [2:0]    ph,
  input logic [IW-1:0] nidx,
  input logic          use_fifo
);

  logic       boundary;
  logic [4:0] bpos;
  int         rd_cnt;

  assign boundary = (ph == 3'd7) && (nidx == '0);
  assign bpos     = 5'd31 - {nidx[1:0] - 2'd1, ph};

  always_ff @(posedge clk) begin
    if (!rst_n)        rd_cnt <= 0;
    else if (boundary) rd_cnt <= 0;
    else if (fifo_rd)  rd_cnt <= rd_cnt + 1;
  end

  assert_sync_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nidx >= IW'(1) && nidx <= IW'(4)) |-> (ser_out == SYNC[bpos]));

  assert_sample_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(use_fifo));

  assert_read_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> !fifo_rd);

  assert_read_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |-> (rd_cnt == 0 || rd_cnt == FRAME_BYTES));

  assert_no_read_on_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> use_fifo);

endmodule

bind cadu_serializer cadu_serializer_chk #(
  .FRAME_BYTES(FRAME_BYTES), .IW(IW), .SYNC(SYNC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_rd(fifo_rd), .ser_out(ser_out),
  .ph(ph), .nidx(nidx), .use_fifo(use_fifo)
);

// File: tb/cadu_serializer_bench.sv
`timescale 1ns/1ps
module cadu_serializer_bench;
  localparam int FRAME = 1100;
  localparam int DEPTH = 5;
  localparam int NPAR  = 32;
  localparam int UNIT  = 4 + FRAME + DEPTH * NPAR;
  localparam int UBITS = UNIT * 8;
  localparam int CW    = FRAME / DEPTH;

  logic       clk = 0, rst_n = 0, frame_ready = 0, offer = 0;
  logic [7:0] fifo_data = 8'h00;
  logic       fifo_rd, ser_out;

  always #2.5 clk = ~clk;

  cadu_serializer u_cadu_serializer (
    .clk(clk), .rst_n(rst_n), .frame_ready(frame_ready),
    .fifo_data(fifo_data), .fifo_rd(fifo_rd), .ser_out(ser_out)
  );

  logic [7:0] fifo_q[$];
  logic [7:0] model_q[$];
  logic [7:0] ub [UNIT];
  logic [7:0] gexp [512];
  int         glog [256];
  logic [7:0] gb [NPAR+1];
  bit         unit_fifo = 0;
  int         edge_n = 0, vectors = 0, errors = 0;
  bit         done = 0;

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return gexp[glog[a] + glog[b]];
  endfunction

  task automatic init_gf();
    logic [7:0] x;
    x = 8'h01;
    for (int i = 0; i < 255; i++) begin
      gexp[i] = x;
      gexp[i+255] = x;
      glog[x] = i;
      x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1D) : {x[6:0], 1'b0};
    end
    gexp[510] = gexp[0];
    gexp[511] = gexp[1];
    for (int i = 0; i <= NPAR; i++) gb[i] = 8'h00;
    gb[0] = 8'h01;
    for (int r = 0; r < NPAR; r++) begin
      for (int i = r + 1; i >= 1; i--) gb[i] = gb[i-1] ^ gm(gb[i], gexp[r]);
      gb[0] = gm(gb[0], gexp[r]);
    end
  endtask

  task automatic build_unit();
    logic [7:0] w [CW+NPAR];
    logic [7:0] c;
    logic [31:0] sync = 32'h1ACFFC1D;
    unit_fifo = frame_ready;
    for (int i = 0; i < 4; i++) ub[i] = sync[8*(3-i) +: 8];
    for (int j = 0; j < FRAME; j++)
      ub[4+j] = unit_fifo ? model_q.pop_front() : 8'h55;
    for (int d = 0; d < DEPTH; d++) begin
      for (int k = 0; k < CW + NPAR; k++) w[k] = (k < CW) ? ub[4 + DEPTH*k + d] : 8'h00;
      for (int i = 0; i < CW; i++) begin
        c = w[i];
        for (int j = 1; j <= NPAR; j++) w[i+j] = w[i+j] ^ gm(c, gb[NPAR-j]);
      end
      for (int s = 0; s < NPAR; s++) ub[4 + FRAME + DEPTH*s + d] = w[CW + s];
    end
  endtask

  task automatic push_frame(input int kind);
    logic [7:0] b;
    int lcg = 12345;
    for (int j = 0; j < FRAME; j++) begin
      case (kind)
        0: b = 8'(j);
        1: begin lcg = lcg * 1103515245 + 12345; b = 8'(lcg >>> 16); end
        2: b = 8'hFF;
        default: b = 8'h00;
      endcase
      fifo_q.push_back(b);
      model_q.push_back(b);
    end
  endtask

  task automatic wait_edge(input int n);
    while (edge_n < n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (fifo_rd) begin
      if (fifo_q.size() == 0) begin
        errors++;
        $display("FAIL R5 read from empty fifo: got rd=1 exp rd=0");
      end else fifo_data <= fifo_q.pop_front();
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (edge_n % UBITS == 0) build_unit();
      edge_n++;
    end
  end

  always @(negedge clk) frame_ready <= offer && (fifo_q.size() >= FRAME);

  always @(negedge clk) begin
    if (!rst_n) begin
      // R8 reset state
      vectors++;
      if (ser_out !== 1'b0 || fifo_rd !== 1'b0) begin
        errors++;
        $display("FAIL R8 reset outputs: got ser=%b rd=%b exp ser=0 rd=0", ser_out, fifo_rd);
      end
    end else if (edge_n > 0) begin
      int  pos, idx, nxt;
      bit  eb, er;
      string tag;
      pos = (edge_n - 1) % UBITS;
      idx = pos / 8;
      nxt = idx + 1;
      eb  = ub[idx][7 - pos % 8];
      er  = (pos % 8 == 5) && nxt >= 4 && nxt < 4 + FRAME && unit_fifo;
      if (idx < 4)              tag = "R1,R3,R2";
      else if (idx < 4 + FRAME) tag = unit_fifo ? "R1,R3,R4,R5" : "R1,R3,R4,R6";
      else                      tag = "R1,R3,R7";
      vectors++;
      if (ser_out !== eb) begin
        errors++;
        $display("FAIL %s ser_out unit byte %0d bit %0d: got %b exp %b", tag, idx, 7 - pos % 8, ser_out, eb);
      end
      vectors++;
      if (fifo_rd !== er) begin
        errors++;
        $display("FAIL %s fifo_rd at unit byte %0d phase %0d: got %b exp %b",
                 unit_fifo ? "R4,R5" : "R4,R6", idx, pos % 8, fifo_rd, er);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    init_gf();
    repeat (4) @(negedge clk);
    push_frame(0);
    offer = 1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    // unit 0 incrementing frame, unit 1 fill; a frame arrives mid unit 1 (R4)
    wait_edge(UBITS + 4000);
    push_frame(1);
    // unit 2 pseudo-random; two frames queued but withheld over unit 3 (R4, R6)
    wait_edge(2 * UBITS + 100);
    push_frame(2);
    push_frame(3);
    offer = 0;
    // units 4 and 5 back-to-back stored frames (R5), unit 6 fill (R6)
    wait_edge(3 * UBITS + 100);
    offer = 1;
    wait_edge(7 * UBITS);
    @(negedge clk);
    vectors++;
    if (fifo_q.size() != 0) begin
      errors++;
      $display("FAIL R5 bytes left in fifo: got %0d exp 0", fifo_q.size());
    end
    finish_run();
  end

endmodule